// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block turns a 64-bit virtual address into a physical address by searching a small, fully associative table of translation entries. Each entry covers a pair of neighbouring pages, an even page and an odd page, and carries a per-entry page-size mask that sets how large both pages are. The caller presents an address, an access kind (instruction fetch, data load or data store) and the current address-space identifier. One clock later the block returns the physical address, a capability-permission bit, and a fault code that tells the caller whether the access may proceed.

The table is filled through a write port. The port takes an entry index and a packed entry word, and the new contents are used by every lookup issued after the next rising edge. The search itself is combinational across all entries. When more than one entry matches, the lowest-numbered one wins. The result is captured in a single output register, which is qualified by a response-valid flag.

Faults come in three kinds. A lookup that matches no entry is a refill fault. A lookup that lands on a half whose valid bit is clear is an invalid fault. A store to a clean half is a modify fault. The refill and invalid faults each come in a load flavour and a store flavour. An entry whose page mask is not one of the nine legal patterns does not produce a translation; it reports its own fault instead.

Top module: `tlb_translator`

## Requirements
- R1: When `wr_en` is high, the entry selected by `wr_idx` takes the value on `wr_entry` at the next rising edge, and all other entries keep their contents. Lookups issued after that edge use the new contents. The layout of `wr_entry`, from the most significant bit down, is: valid (1), global (1), region (2), vpn2 (27), asid (8), mask (16), then the odd half, then the even half. Each half is, from the most significant bit down: pfn (24), cache attribute (3), dirty (1), valid (1), load capability (1), store capability (1). The whole word is 117 bits.
- R2: An entry matches only when all of the following hold:
  - its valid bit is set;
  - its region equals VA[63:62];
  - its vpn2 equals VA[39:13] at every bit position where the zero-extended mask bit is 0;
  - either its asid equals `req_asid` or its global bit is set.
- R3: When several entries match, the result comes from the lowest-numbered matching entry.
- R4: The mask selects which VA bit picks the odd half (bit = 1) or the even half (bit = 0):

  | Mask | Select bit |
  |---|---|
  | 0x0000 | 12 |
  | 0x0003 | 14 |
  | 0x000F | 16 |
  | 0x003F | 18 |
  | 0x00FF | 20 |
  | 0x03FF | 22 |
  | 0x0FFF | 24 |
  | 0x3FFF | 26 |
  | 0xFFFF | 28 |

- R5: For a select bit s, the physical address is pfn[23:s-12] placed above VA[s-1:0]. This gives a 36-bit value, which is zero-extended to 64 bits.
- R6: A lookup that matches no entry gives fault code 2 for a store (`req_acc` = 2). For any other access kind (fetch = 0, load = 1) it gives fault code 1.
- R7: A match on a half whose valid bit is clear gives fault code 4 for a store and fault code 3 otherwise.
- R8: A store to a matched, valid half whose dirty bit is clear gives fault code 5. Loads and fetches of that half succeed.
- R9: On success (fault code 0), `rsp_cap` is the half's store-capability bit for a store and its load-capability bit otherwise.
- R10: A matching entry whose mask is not one of the nine legal patterns gives fault code 6 and no translation.
- R11: `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high. On any nonzero fault, `rsp_pa` and `rsp_cap` are zero.
- R12: After reset all entries are invalid, so every lookup misses. Before the first request `rsp_vld`, `rsp_pa`, `rsp_cap` and `rsp_fault` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 3 | Entry number to write |
| wr_entry | input | 117 | Packed entry contents |
| req_vld | input | 1 | Lookup request this cycle |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_asid | input | 8 | Current address-space identifier |
| rsp_vld | output | 1 | Registered result valid |
| rsp_pa | output | 64 | Physical address, zero on fault |
| rsp_cap | output | 1 | Capability-permission bit |
| rsp_fault | output | 3 | Fault code, 0 for success |

## Verification
The assertions check several properties on every cycle:
- the one-cycle response timing;
- zeroed outputs on any fault;
- zero upper address bits;
- that the chosen entry is always the lowest-numbered match;
- that a miss always yields a refill code;
- that a modify fault only follows a store;
- that each write lands in exactly one entry.

Only the bench's scenarios can show that translations are numerically correct. That covers the page-size select bit for each of the nine masks, how address bits from the frame number and from the offset are spliced, the effect of the global bit and of the region and asid compares, and how the capability bit is chosen per access kind. For these, each lookup is compared against an independent model of the table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int TLB_ENTRIES = 8;
    localparam int VA_W        = 64;
    localparam int PA_W        = 64;
    localparam int PFN_W       = 24;
    localparam int VPN2_W      = 27;
    localparam int ASID_W      = 8;
    localparam int MASK_W      = 16;
    localparam int ATTR_W      = 3;
    localparam int REGION_W    = 2;
    localparam int PAGE_SHIFT  = 12;
    localparam int VPN_LSB     = PAGE_SHIFT + 1;
    localparam int VPN_MSB     = VPN_LSB + VPN2_W - 1;
    localparam int REGION_LSB  = VA_W - REGION_W;
    localparam int PHYS_W      = PFN_W + PAGE_SHIFT;
    localparam int SEL_MAX     = PAGE_SHIFT + MASK_W;
    localparam int SEL_STEPS   = (MASK_W / 2) + 1;
    localparam int SEL_W       = $clog2(SEL_MAX + 1);

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
        logic              cap_ld;
        logic              cap_st;
    } tlb_half_t;

    typedef struct packed {
        logic                valid;
        logic                glob;
        logic [REGION_W-1:0] region;
        logic [VPN2_W-1:0]   vpn2;
        logic [ASID_W-1:0]   asid;
        logic [MASK_W-1:0]   mask;
        tlb_half_t           odd;
        tlb_half_t           even;
    } tlb_entry_t;

    localparam int ENTRY_W = $bits(tlb_entry_t);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_REFILL_LD = 3'd1,
        FLT_REFILL_ST = 3'd2,
        FLT_INVAL_LD  = 3'd3,
        FLT_INVAL_ST  = 3'd4,
        FLT_MODIFY    = 3'd5,
        FLT_BAD_MASK  = 3'd6
    } fault_t;

endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_data,
    output tlb_entry_t       entries [ENTRIES]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    entries[i] <= wr_data;
                end
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (entries[g] == $past(wr_data))) else $error("write lost"); // R1
        AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(entries[g])) else $error("entry disturbed"); // R1
    end

endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  tlb_entry_t         entries [ENTRIES],
    input  logic [VA_W-1:0]    va,
    input  logic [ASID_W-1:0]  asid,
    output logic [ENTRIES-1:0] match_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output tlb_entry_t         hit_entry
);

    logic [VPN2_W-1:0]   va_vpn2;
    logic [REGION_W-1:0] va_region;
    logic                va_unused;

    assign va_vpn2   = va[VPN_MSB:VPN_LSB];
    assign va_region = va[VA_W-1:REGION_LSB];
    assign va_unused = ^{va[REGION_LSB-1:VPN_MSB+1], va[VPN_LSB-1:0]};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN2_W-1:0] care;
        logic              tag_eq;
        logic              space_eq;

        assign care     = ~{{(VPN2_W - MASK_W){1'b0}}, entries[g].mask};
        assign tag_eq   = ((va_vpn2 ^ entries[g].vpn2) & care) == '0;
        assign space_eq = entries[g].glob || (entries[g].asid == asid);
        assign match_vec[g] = entries[g].valid
                           && (entries[g].region == va_region)
                           && tag_eq
                           && space_eq;
    end

    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
        hit_entry = entries[hit_idx];
    end

endmodule

// File: rtl/tlb_page_resolve.sv
module tlb_page_resolve
    import tlb_pkg::*;
(
    input  logic             hit,
    input  tlb_entry_t       ent,
    input  logic [SEL_MAX:0] va_low,
    input  acc_t             acc,
    output logic [PA_W-1:0]  pa,
    output logic             cap,
    output fault_t           fault
);

    logic              mask_ok;
    logic [SEL_W-1:0]  sel_bit;
    logic              odd_pick;
    tlb_half_t         half;
    logic [PHYS_W-1:0] keep;
    logic [PHYS_W-1:0] phys;
    logic              is_store;
    logic              ent_unused;

    assign ent_unused = ^{ent.valid, ent.glob, ent.region, ent.vpn2, ent.asid,
                          ent.odd.attr, ent.even.attr};

    always_comb begin
        mask_ok = 1'b0;
        sel_bit = SEL_W'(PAGE_SHIFT);
        for (int k = 0; k < SEL_STEPS; k++) begin
            if (ent.mask == MASK_W'((32'd1 << (2 * k)) - 32'd1)) begin
                mask_ok = 1'b1;
                sel_bit = SEL_W'(PAGE_SHIFT + 2 * k);
            end
        end
    end

    always_comb begin
        odd_pick = va_low[sel_bit];
        half     = odd_pick ? ent.odd : ent.even;
        keep     = (PHYS_W'(1) << sel_bit) - PHYS_W'(1);
        phys     = ({half.pfn, {PAGE_SHIFT{1'b0}}} & ~keep) | (PHYS_W'(va_low) & keep);
        is_store = (acc == ACC_STORE);
    end

    always_comb begin
        pa    = '0;
        cap   = 1'b0;
        fault = FLT_NONE;
        if (!hit) begin
            fault = is_store ? FLT_REFILL_ST : FLT_REFILL_LD;
        end else if (!mask_ok) begin
            fault = FLT_BAD_MASK;
        end else if (!half.valid) begin
            fault = is_store ? FLT_INVAL_ST : FLT_INVAL_LD;
        end else if (is_store && !half.dirty) begin
            fault = FLT_MODIFY;
        end else begin
            pa  = PA_W'(phys);
            cap = is_store ? half.cap_st : half.cap_ld;
        end
    end

endmodule

// File: rtl/tlb_translator.sv
module tlb_translator
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic               req_vld,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_acc,
    input  logic [ASID_W-1:0]  req_asid,
    output logic               rsp_vld,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_cap,
    output logic [2:0]         rsp_fault
);

    tlb_entry_t         entries [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    tlb_entry_t         hit_entry;
    logic [PA_W-1:0]    nxt_pa;
    logic               nxt_cap;
    fault_t             nxt_fault;
    fault_t             fault_q;

    tlb_entry_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (tlb_entry_t'(wr_entry)),
        .entries (entries)
    );

    tlb_match_unit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
        .entries   (entries),
        .va        (req_va),
        .asid      (req_asid),
        .match_vec (match_vec),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_entry (hit_entry)
    );

    tlb_page_resolve u_resolve (
        .hit    (hit),
        .ent    (hit_entry),
        .va_low (req_va[SEL_MAX:0]),
        .acc    (acc_t'(req_acc)),
        .pa     (nxt_pa),
        .cap    (nxt_cap),
        .fault  (nxt_fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_vld <= 1'b0;
            rsp_pa  <= '0;
            rsp_cap <= 1'b0;
            fault_q <= FLT_NONE;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_pa  <= nxt_pa;
                rsp_cap <= nxt_cap;
                fault_q <= nxt_fault;
            end
        end
    end

    assign rsp_fault = fault_q;

    logic [ENTRIES-1:0] below_hit;
    assign below_hit = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld) else $error("missing response"); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld) else $error("spurious response"); // R11
    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && fault_q != FLT_NONE) |-> (rsp_pa == '0 && !rsp_cap)) else $error("fault leaks address"); // R11
    AST_PA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pa[PA_W-1:PHYS_W] == '0) else $error("upper address bits set"); // R5
    AST_LOWEST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match_vec[hit_idx] && (match_vec & below_hit) == '0)) else $error("priority broken"); // R3
    AST_MISS_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !hit) |=> (fault_q == FLT_REFILL_LD || fault_q == FLT_REFILL_ST)) else $error("miss without refill"); // R6
    AST_MODIFY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && fault_q == FLT_MODIFY) |-> ($past(req_acc) == 2'd2)) else $error("modify on non-store"); // R8

endmodule

// File: tb/test_tlb_translator.sv
module test_tlb_translator;
    import tlb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [2:0]         wr_idx = '0;
    logic [ENTRY_W-1:0] wr_entry = '0;
    logic               req_vld = 1'b0;
    logic [63:0]        req_va = '0;
    logic [1:0]         req_acc = '0;
    logic [7:0]         req_asid = '0;
    logic               rsp_vld;
    logic [63:0]        rsp_pa;
    logic               rsp_cap;
    logic [2:0]         rsp_fault;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_translator i_tlb_translator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .req_vld(req_vld), .req_va(req_va), .req_acc(req_acc), .req_asid(req_asid),
        .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_cap(rsp_cap), .rsp_fault(rsp_fault)
    );

    typedef struct {
        logic [63:0] pa;
        logic        cap;
        logic [2:0]  fault;
        string       tag;
    } exp_t;

    exp_t       sb_q[$];
    tlb_entry_t shadow [TLB_ENTRIES];
    int         checks = 0;
    int         errors = 0;
    int         pushed = 0;
    int         popped = 0;
    bit         done = 1'b0;

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic tlb_half_t mk_half(logic [23:0] pfn, bit dirty, bit vld, bit cld, bit cst);
        tlb_half_t h;
        h.pfn = pfn; h.attr = 3'd3; h.dirty = dirty; h.valid = vld; h.cap_ld = cld; h.cap_st = cst;
        return h;
    endfunction

    function automatic tlb_entry_t mk_entry(bit vld, bit glob, logic [1:0] region, logic [26:0] vpn2,
                                            logic [7:0] asid, logic [15:0] mask,
                                            tlb_half_t ev, tlb_half_t od);
        tlb_entry_t e;
        e.valid = vld; e.glob = glob; e.region = region; e.vpn2 = vpn2;
        e.asid = asid; e.mask = mask; e.even = ev; e.odd = od;
        return e;
    endfunction

    function automatic logic [63:0] mk_va(logic [1:0] region, logic [26:0] vpn2, logic [12:0] off);
        return {region, 22'd0, vpn2, off};
    endfunction

    // Independent reference model built from the requirement text
    function automatic exp_t model(logic [63:0] va, logic [1:0] acc, logic [7:0] asid, string tag);
        exp_t       r;
        int         found;
        int         sel;
        bit         st;
        bit         ok;
        tlb_entry_t e;
        tlb_half_t  h;
        r.pa = '0; r.cap = 1'b0; r.fault = 3'd0; r.tag = tag;
        st = (acc == 2'd2);
        found = -1;
        for (int i = 0; i < TLB_ENTRIES; i++) begin
            e = shadow[i];
            ok = e.valid && (e.region == va[63:62]) && (e.glob || e.asid == asid);
            for (int b = 0; b < 27; b++) begin
                if (!(b < 16 && e.mask[b]) && e.vpn2[b] != va[13 + b]) ok = 1'b0;
            end
            if (ok && found < 0) found = i;
        end
        if (found < 0) begin
            r.fault = st ? 3'd2 : 3'd1;
        end else begin
            e = shadow[found];
            case (e.mask)
                16'h0000: sel = 12;
                16'h0003: sel = 14;
                16'h000f: sel = 16;
                16'h003f: sel = 18;
                16'h00ff: sel = 20;
                16'h03ff: sel = 22;
                16'h0fff: sel = 24;
                16'h3fff: sel = 26;
                16'hffff: sel = 28;
                default:  sel = -1;
            endcase
            if (sel < 0) begin
                r.fault = 3'd6;
            end else begin
                h = va[sel] ? e.odd : e.even;
                if (!h.valid) r.fault = st ? 3'd4 : 3'd3;
                else if (st && !h.dirty) r.fault = 3'd5;
                else begin
                    r.pa = {28'd0, h.pfn, 12'd0};
                    for (int b = 0; b < sel; b++) r.pa[b] = va[b];
                    r.cap = st ? h.cap_st : h.cap_ld;
                end
            end
        end
        return r;
    endfunction

    task automatic write_entry(int idx, tlb_entry_t e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_entry = e;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[idx] = e;
    endtask

    task automatic lookup(logic [63:0] va, logic [1:0] acc, logic [7:0] asid, string tag, bit hold = 1'b0);
        @(negedge clk);
        sb_q.push_back(model(va, acc, asid, tag));
        pushed++;
        req_vld = 1'b1; req_va = va; req_acc = acc; req_asid = asid;
        if (!hold) begin
            @(negedge clk);
            req_vld = 1'b0;
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11", "unexpected response", 64'(rsp_vld), 64'd0);
            end else begin
                exp_t x;
                x = sb_q.pop_front();
                popped++;
                check(rsp_fault == x.fault, x.tag, "fault", 64'(rsp_fault), 64'(x.fault));
                check(rsp_pa == x.pa, x.tag, "pa", rsp_pa, x.pa);
                check(rsp_cap == x.cap, x.tag, "cap", 64'(rsp_cap), 64'(x.cap));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R11", "watchdog", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tlb_entry_t e;
        for (int i = 0; i < TLB_ENTRIES; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(rsp_vld == 1'b0, "R12", "rsp_vld after reset", 64'(rsp_vld), 64'd0);
        check(rsp_pa == '0, "R12", "rsp_pa after reset", rsp_pa, 64'd0);
        check(rsp_fault == 3'd0 && rsp_cap == 1'b0, "R12", "fault/cap after reset", 64'(rsp_fault), 64'd0);
        lookup(mk_va(2'd0, 27'h0, 13'h0), 2'd1, 8'd0, "R12");
        lookup(mk_va(2'd1, 27'h55, 13'h10), 2'd0, 8'd3, "R6");
        lookup(mk_va(2'd1, 27'h55, 13'h10), 2'd2, 8'd3, "R6");

        // 4 KiB pair, asid 5
        e = mk_entry(1, 0, 2'd0, 27'h1234, 8'd5, 16'h0000,
                     mk_half(24'h00ABC, 1, 1, 1, 0), mk_half(24'h00DEF, 0, 1, 0, 1));
        write_entry(0, e);
        lookup(mk_va(2'd0, 27'h1234, 13'h0123), 2'd1, 8'd5, "R5");
        lookup(mk_va(2'd0, 27'h1234, 13'h1456), 2'd1, 8'd5, "R4");
        lookup(mk_va(2'd0, 27'h1234, 13'h1456), 2'd2, 8'd5, "R8");
        lookup(mk_va(2'd0, 27'h1234, 13'h1456), 2'd0, 8'd5, "R8");
        lookup(mk_va(2'd0, 27'h1234, 13'h0010), 2'd2, 8'd5, "R9");
        lookup(mk_va(2'd0, 27'h1234, 13'h0010), 2'd1, 8'd5, "R9");
        lookup(mk_va(2'd0, 27'h1234, 13'h1010), 2'd0, 8'd5, "R9");
        lookup(mk_va(2'd0, 27'h1234, 13'h0123), 2'd1, 8'd6, "R2");
        lookup(mk_va(2'd1, 27'h1234, 13'h0123), 2'd1, 8'd5, "R2");
        lookup(mk_va(2'd0, 27'h1235, 13'h0123), 2'd1, 8'd5, "R2");

        // global entry and an invalid twin
        e = mk_entry(1, 1, 2'd0, 27'h2000, 8'd9, 16'h0000,
                     mk_half(24'h111111, 1, 1, 1, 1), mk_half(24'h222222, 1, 1, 0, 0));
        write_entry(1, e);
        e = mk_entry(0, 1, 2'd0, 27'h3000, 8'd0, 16'h0000,
                     mk_half(24'h333333, 1, 1, 1, 1), mk_half(24'h333333, 1, 1, 1, 1));
        write_entry(3, e);
        lookup(mk_va(2'd0, 27'h2000, 13'h0abc), 2'd2, 8'd3, "R2");
        lookup(mk_va(2'd0, 27'h3000, 13'h0abc), 2'd1, 8'd0, "R2");

        // R1: rewrite entry 0 with new frames
        e = mk_entry(1, 0, 2'd0, 27'h1234, 8'd5, 16'h0000,
                     mk_half(24'h0F0F0F, 1, 1, 0, 1), mk_half(24'h00DEF, 1, 1, 1, 0));
        write_entry(0, e);
        lookup(mk_va(2'd0, 27'h1234, 13'h0123), 2'd1, 8'd5, "R1");
        lookup(mk_va(2'd0, 27'h1234, 13'h1456), 2'd2, 8'd5, "R1");

        // R4/R5: every legal mask
        for (int k = 0; k < 9; k++) begin
            logic [15:0] m;
            logic [63:0] va;
            int          sel;
            m = 16'((32'd1 << (2 * k)) - 1);
            sel = 12 + 2 * k;
            e = mk_entry(1, 0, 2'd2, 27'h5A5A5A5 & ~{11'd0, m}, 8'd7, m,
                         mk_half(24'hC3A5F1, 1, 1, 1, 0), mk_half(24'h9B6E27, 1, 1, 0, 1));
            write_entry(4, e);
            for (int h = 0; h < 2; h++) begin
                va = mk_va(2'd2, 27'h5A5A5A5 & ~{11'd0, m}, 13'd0);
                for (int b = 0; b < sel; b++) va[b] = b[0] ^ b[2];
                va[sel] = h[0];
                lookup(va, 2'd1, 8'd7, "R4");
                lookup(va, 2'd2, 8'd7, "R5");
            end
        end

        // R3: two identical matches
        e = mk_entry(1, 0, 2'd3, 27'h777, 8'd1, 16'h0000,
                     mk_half(24'h000222, 1, 1, 1, 1), mk_half(24'h000222, 1, 1, 1, 1));
        write_entry(2, e);
        e = mk_entry(1, 1, 2'd3, 27'h777, 8'd4, 16'h0000,
                     mk_half(24'h000555, 1, 1, 0, 0), mk_half(24'h000555, 1, 1, 0, 0));
        write_entry(5, e);
        lookup(mk_va(2'd3, 27'h777, 13'h0042), 2'd1, 8'd1, "R3");
        lookup(mk_va(2'd3, 27'h777, 13'h0042), 2'd1, 8'd2, "R3");
        e = shadow[2]; e.valid = 1'b0;
        write_entry(2, e);
        lookup(mk_va(2'd3, 27'h777, 13'h0042), 2'd1, 8'd1, "R3");

        // R7: invalid half
        e = mk_entry(1, 0, 2'd1, 27'h4444, 8'd8, 16'h0003,
                     mk_half(24'h000AAA, 1, 0, 1, 1), mk_half(24'h000BBB, 1, 1, 1, 1));
        write_entry(7, e);
        lookup(mk_va(2'd1, 27'h4444, 13'h0100), 2'd1, 8'd8, "R7");
        lookup(mk_va(2'd1, 27'h4444, 13'h0100), 2'd2, 8'd8, "R7");
        lookup(mk_va(2'd1, 27'h4444, 13'h0100) | 64'h4000, 2'd2, 8'd8, "R7");

        // R10: illegal masks
        e = mk_entry(1, 0, 2'd1, 27'h6000, 8'd8, 16'h0001,
                     mk_half(24'h000CCC, 1, 1, 1, 1), mk_half(24'h000CCC, 1, 1, 1, 1));
        write_entry(6, e);
        lookup(mk_va(2'd1, 27'h6000, 13'h0100), 2'd1, 8'd8, "R10");
        e.mask = 16'h0100;
        write_entry(6, e);
        lookup(mk_va(2'd1, 27'h6000, 13'h0100), 2'd2, 8'd8, "R10");

        // R11: back-to-back requests
        lookup(mk_va(2'd0, 27'h1234, 13'h0001), 2'd1, 8'd5, "R11", 1'b1);
        lookup(mk_va(2'd0, 27'h2000, 13'h0002), 2'd0, 8'd5, "R11", 1'b1);
        lookup(mk_va(2'd2, 27'h0, 13'h0003), 2'd2, 8'd5, "R11");
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R11", "outstanding results", 64'(sb_q.size()), 64'd0);
        check(popped == pushed, "R11", "response count", 64'(popped), 64'(pushed));
        check(rsp_vld == 1'b0, "R11", "rsp_vld idle", 64'(rsp_vld), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule